// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a configurable number of external interrupt lines and turns them into a small set of processor-facing request outputs. Each input has its own settings, all held in the block: an active sense (high or rising versus low or falling), a choice of level or edge sensitivity, an option to catch both edges, an enable bit and a pending bit. Every input that is pending and enabled is steered by its own routing word to one numbered request pin, to a non-maskable output, and/or to a secondary yield output.

Software reaches the block over a plain 32-bit register bus with byte offsets. Settings for sources are packed 32 to a word. Enables change only through separate write-one-to-set and write-one-to-clear words, and a read-only word reports them. A single command word lets software set or clear the edge latch of one source by number. Inputs are asynchronous. They pass through a two-stage synchronizer before their level or edge is judged.

Top module: `irq_share_ctrl`

Register map (byte offsets; word `w` of a bank holds sources `32*w` to `32*w+31`, with source `n` at bit `n%32`):
`0x000+4w` sense, `0x040+4w` edge mode, `0x080+4w` both-edge, `0x0C0+4w` enable set (write-only), `0x100+4w` enable clear (write-only), `0x140+4w` enable status (read-only), `0x180+4w` pending (read-only), `0x1C0` edge command, `0x200+4n` routing word of source `n`.

## Requirements
- R1: After synchronous reset, all sense, edge-mode, both-edge, enable, latch and routing state is zero and every output is low. With all inputs low, each pending bit therefore reads 1, because a level source with sense 0 is active low.
- R2: A level source (edge-mode bit 0) has a pending bit that follows its synchronized input: equal to the input when its sense bit is 1, and inverted when it is 0. Nothing is latched.
- R3: An edge source (edge-mode bit 1) with both-edge bit 0 sets its latch on a rising input when its sense bit is 1, and on a falling input when its sense bit is 0. The latch stays set until an edge command clears it. Its pending bit equals the latch.
- R4: An edge source whose both-edge bit is 1 sets its latch on every input transition, whatever its sense bit.
- R5: Writing the enable-set word sets the enables of the sources whose data bits are 1. Writing the enable-clear word clears them. Zero data bits change nothing. The enable-status word reads back the enables. With every enable cleared, all outputs are low.
- R6: Writing the edge command with bit 31 = 1 sets the latch of the source numbered by bits 30:0. Bit 31 = 0 clears that latch. A number at or above the source count has no effect.
- R7: Request pin `p` is high when at least one source is pending and enabled and its routing word has bit 31 set and bits 5:0 equal to `p`. A selector at or above the pin count drives no pin.
- R8: Routing bit 30 sends a pending enabled source to the non-maskable output, and bit 29 sends it to the yield output. Each acts independently of bit 31.
- R9: A source's sense, edge-mode and both-edge bits and its routing word read back at the bank word and bit given in the map. A routing word reads back only bits 31, 30, 29 and 5:0. All other bits read 0.
- R10: Read data appears on the bus one cycle after the read strobe and holds until the next read. Write-only, misaligned and unmapped offsets read 0.
- R11: The outputs are registered. After a level input changes, its pin changes on the third rising clock edge. After an enable or routing write, the outputs follow on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_SRC | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_irq | output | NUM_PINS | Numbered request pins |
| nmi_irq | output | 1 | Non-maskable request |
| yield_irq | output | 1 | Secondary yield request |

## Verification
A level input reaches its pending bit after two rising edges and its pin after three. An edge latch sets on the third edge and its pin follows on the fourth. An enable or routing write reaches the outputs one edge after the write, and read data one edge after the strobe. The timing check drives an input just after a falling edge and samples the pin two and then three falling edges later, expecting it low and then high. Every other comparison waits five cycles after its stimulus, so all of these paths have settled, and all sampling happens at falling edges, well away from the edge that updates the outputs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets of the register regions
  localparam int unsigned OFF_SENSE   = 'h000;
  localparam int unsigned OFF_EDGE    = 'h040;
  localparam int unsigned OFF_BOTH    = 'h080;
  localparam int unsigned OFF_ENSET   = 'h0C0;
  localparam int unsigned OFF_ENCLR   = 'h100;
  localparam int unsigned OFF_ENSTAT  = 'h140;
  localparam int unsigned OFF_PEND    = 'h180;
  localparam int unsigned OFF_EDGECMD = 'h1C0;
  localparam int unsigned OFF_ROUTE   = 'h200;
  // Each bank spans 16 words (up to 512 sources)
  localparam int unsigned BANK_WORDS  = 16;

  // Routing word fields
  localparam int unsigned RT_PIN_BIT = 31;
  localparam int unsigned RT_NMI_BIT = 30;
  localparam int unsigned RT_YLD_BIT = 29;
  localparam int unsigned SEL_W      = 6;

  typedef struct packed {
    logic             to_pin;
    logic             to_nmi;
    logic             to_yld;
    logic [SEL_W-1:0] sel;
  } route_t;
endpackage

// File: rtl/irqc_src_front.sv
// Per-source synchronizer, edge detection, edge latch and pending logic
module irqc_src_front #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] raw_in,
  input  logic [NUM_SRC-1:0] sense,
  input  logic [NUM_SRC-1:0] edge_mode,
  input  logic [NUM_SRC-1:0] both_edge,
  input  logic [NUM_SRC-1:0] cmd_set,
  input  logic [NUM_SRC-1:0] cmd_clr,
  output logic [NUM_SRC-1:0] latch_q,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    logic meta_q, sync_q, prev_q;
    logic lat_q;
    logic rise, fall, hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= raw_in[gi];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;
    assign hit  = edge_mode[gi] &
                  (both_edge[gi] ? (rise | fall) : (sense[gi] ? rise : fall));

    // A hardware edge takes precedence over a clear command in the same cycle
    always_ff @(posedge clk) begin
      if (rst)                       lat_q <= 1'b0;
      else if (hit || cmd_set[gi])   lat_q <= 1'b1;
      else if (cmd_clr[gi])          lat_q <= 1'b0;
    end

    assign latch_q[gi] = lat_q;
    assign pend[gi]    = edge_mode[gi] ? lat_q : ~(sync_q ^ sense[gi]);
  end
endmodule

// File: rtl/irqc_regs.sv
// Register decode, configuration storage and registered read path
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic [NUM_SRC-1:0]          pend,
  output logic [NUM_SRC-1:0]          sense_q,
  output logic [NUM_SRC-1:0]          edge_q,
  output logic [NUM_SRC-1:0]          both_q,
  output logic [NUM_SRC-1:0]          en_q,
  output route_t [NUM_SRC-1:0]        routes_q,
  output logic [NUM_SRC-1:0]          cmd_set,
  output logic [NUM_SRC-1:0]          cmd_clr,
  output logic                        edge_cmd_wr,
  output logic [31:0]                 bus_rdata
);
  localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32;
  localparam int unsigned PAD_W     = NUM_WORDS * 32;
  localparam int unsigned WIDX_W    = ADDR_W - 2;
  localparam int unsigned RT_BASE_W = OFF_ROUTE / 4;

  logic              aligned;
  logic [WIDX_W-1:0] widx;
  logic [3:0]        bank_w;
  logic [WIDX_W-1:0] rt_idx;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[ADDR_W-1:2];
  assign bank_w  = widx[3:0];
  assign rt_idx  = widx - WIDX_W'(RT_BASE_W);

  function automatic logic in_bank(input logic al, input logic [WIDX_W-1:0] w,
                                   input int unsigned base);
    return al && (32'(w[WIDX_W-1:4]) == base / (4 * BANK_WORDS))
              && (32'(w[3:0]) < NUM_WORDS);
  endfunction

  logic hit_sense, hit_edge, hit_both, hit_enset, hit_enclr;
  logic hit_enstat, hit_pend, hit_route;

  assign hit_sense  = in_bank(aligned, widx, OFF_SENSE);
  assign hit_edge   = in_bank(aligned, widx, OFF_EDGE);
  assign hit_both   = in_bank(aligned, widx, OFF_BOTH);
  assign hit_enset  = in_bank(aligned, widx, OFF_ENSET);
  assign hit_enclr  = in_bank(aligned, widx, OFF_ENCLR);
  assign hit_enstat = in_bank(aligned, widx, OFF_ENSTAT);
  assign hit_pend   = in_bank(aligned, widx, OFF_PEND);
  assign hit_route  = aligned && (widx >= WIDX_W'(RT_BASE_W)) && (32'(rt_idx) < NUM_SRC);

  route_t wr_route;
  assign wr_route = '{to_pin: bus_wdata[RT_PIN_BIT],
                      to_nmi: bus_wdata[RT_NMI_BIT],
                      to_yld: bus_wdata[RT_YLD_BIT],
                      sel:    bus_wdata[SEL_W-1:0]};

  // Configuration writes
  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q  <= '0;
      edge_q   <= '0;
      both_q   <= '0;
      en_q     <= '0;
      routes_q <= '0;
    end else if (bus_wr) begin
      for (int unsigned n = 0; n < NUM_SRC; n++) begin
        if (32'(bank_w) == n / 32) begin
          if (hit_sense) sense_q[n] <= bus_wdata[n % 32];
          if (hit_edge)  edge_q[n]  <= bus_wdata[n % 32];
          if (hit_both)  both_q[n]  <= bus_wdata[n % 32];
          if (hit_enset && bus_wdata[n % 32]) en_q[n] <= 1'b1;
          if (hit_enclr && bus_wdata[n % 32]) en_q[n] <= 1'b0;
        end
        if (hit_route && (rt_idx == WIDX_W'(n))) routes_q[n] <= wr_route;
      end
    end
  end

  // Edge command: bit 31 chooses set or clear, bits 30:0 name the source
  logic [30:0] cmd_num;
  assign edge_cmd_wr = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_EDGECMD));
  assign cmd_num     = bus_wdata[30:0];

  always_comb begin
    for (int unsigned n = 0; n < NUM_SRC; n++) begin
      cmd_set[n] = edge_cmd_wr &&  bus_wdata[31] && (cmd_num == 31'(n));
      cmd_clr[n] = edge_cmd_wr && !bus_wdata[31] && (cmd_num == 31'(n));
    end
  end

  // Read path
  logic [PAD_W-1:0] sense_pad, edge_pad, both_pad, en_pad, pend_pad;
  logic [31:0]      rd_word;

  assign sense_pad = PAD_W'(sense_q);
  assign edge_pad  = PAD_W'(edge_q);
  assign both_pad  = PAD_W'(both_q);
  assign en_pad    = PAD_W'(en_q);
  assign pend_pad  = PAD_W'(pend);

  always_comb begin
    rd_word = '0;
    for (int unsigned w = 0; w < NUM_WORDS; w++) begin
      if (32'(bank_w) == w) begin
        if (hit_sense)  rd_word = sense_pad[w*32 +: 32];
        if (hit_edge)   rd_word = edge_pad[w*32 +: 32];
        if (hit_both)   rd_word = both_pad[w*32 +: 32];
        if (hit_enstat) rd_word = en_pad[w*32 +: 32];
        if (hit_pend)   rd_word = pend_pad[w*32 +: 32];
      end
    end
    if (hit_route) begin
      for (int unsigned n = 0; n < NUM_SRC; n++) begin
        if (rt_idx == WIDX_W'(n))
          rd_word = {routes_q[n].to_pin, routes_q[n].to_nmi, routes_q[n].to_yld,
                     {(32 - 3 - SEL_W){1'b0}}, routes_q[n].sel};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/irqc_route.sv
// Merges pending, enabled sources onto the request outputs
module irqc_route
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    pend,
  input  logic [NUM_SRC-1:0]    en,
  input  route_t [NUM_SRC-1:0]  routes,
  output logic [NUM_PINS-1:0]   pin_q,
  output logic                  nmi_q,
  output logic                  yld_q
);
  logic [NUM_SRC-1:0] live, want_nmi, want_yld;
  assign live = pend & en;

  for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_side
    assign want_nmi[gs] = live[gs] & routes[gs].to_nmi;
    assign want_yld[gs] = live[gs] & routes[gs].to_yld;
  end

  for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
    logic [NUM_SRC-1:0] want;
    logic               out_q;
    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_s
      assign want[gs] = live[gs] & routes[gs].to_pin & (routes[gs].sel == SEL_W'(gp));
    end
    always_ff @(posedge clk) begin
      if (rst) out_q <= 1'b0;
      else     out_q <= |want;
    end
    assign pin_q[gp] = out_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b0;
      yld_q <= 1'b0;
    end else begin
      nmi_q <= |want_nmi;
      yld_q <= |want_yld;
    end
  end
endmodule

// File: rtl/irq_share_ctrl.sv
// Top level: shared interrupt source controller
module irq_share_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] pin_irq,
  output logic                nmi_irq,
  output logic                yield_irq
);
  logic [NUM_SRC-1:0] sense_q, edge_q, both_q, en_q;
  logic [NUM_SRC-1:0] cmd_set, cmd_clr, latch_q, pend;
  route_t [NUM_SRC-1:0] routes_q;
  logic               edge_cmd_wr;

  irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pend       (pend),
    .sense_q    (sense_q),
    .edge_q     (edge_q),
    .both_q     (both_q),
    .en_q       (en_q),
    .routes_q   (routes_q),
    .cmd_set    (cmd_set),
    .cmd_clr    (cmd_clr),
    .edge_cmd_wr(edge_cmd_wr),
    .bus_rdata  (bus_rdata)
  );

  irqc_src_front #(.NUM_SRC(NUM_SRC)) i_front (
    .clk      (clk),
    .rst      (rst),
    .raw_in   (irq_in),
    .sense    (sense_q),
    .edge_mode(edge_q),
    .both_edge(both_q),
    .cmd_set  (cmd_set),
    .cmd_clr  (cmd_clr),
    .latch_q  (latch_q),
    .pend     (pend)
  );

  irqc_route #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) i_route (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend),
    .en    (en_q),
    .routes(routes_q),
    .pin_q (pin_irq),
    .nmi_q (nmi_irq),
    .yld_q (yield_irq)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_irq,
  input logic                nmi_irq,
  input logic                yield_irq,
  input logic [NUM_SRC-1:0]  en_q,
  input logic [NUM_SRC-1:0]  latch_q,
  input logic                edge_cmd_wr
);
  localparam int unsigned MAP_END = OFF_ROUTE + 4 * NUM_SRC;

  // R10: read data holds between reads
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R10: reads beyond the routing region return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (32'(bus_addr) >= MAP_END)) |=> (bus_rdata == 32'd0));

  // R5: enable-set write turns on the written ones (word 0)
  assert_enable_set_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == ADDR_W'(OFF_ENSET)))
      |=> ((en_q[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R5: enable-clear write turns off the written ones (word 0)
  assert_enable_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == ADDR_W'(OFF_ENCLR)))
      |=> ((en_q[31:0] & $past(bus_wdata)) == 32'd0));

  // R5: nothing enabled means quiet outputs one edge later
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> ((pin_irq == '0) && !nmi_irq && !yield_irq));

  // R3: latches only drop through an edge command
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !edge_cmd_wr |=> (($past(latch_q) & ~latch_q) == '0));
endmodule

bind irq_share_ctrl irqc_checker #(
  .NUM_SRC (NUM_SRC),
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W)
) i_irqc_checker (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_irq    (pin_irq),
  .nmi_irq    (nmi_irq),
  .yield_irq  (yield_irq),
  .en_q       (en_q),
  .latch_q    (latch_q),
  .edge_cmd_wr(edge_cmd_wr)
);

// File: tb/test_irq_share_ctrl.sv
module test_irq_share_ctrl;
  localparam int unsigned NS = 64;
  localparam int unsigned NP = 8;
  localparam int unsigned AW = 12;
  localparam int unsigned CLK_PERIOD = 10;

  localparam int unsigned A_SENSE = 'h000, A_EDGE = 'h040, A_BOTH = 'h080;
  localparam int unsigned A_ENSET = 'h0C0, A_ENCLR = 'h100, A_ENSTAT = 'h140;
  localparam int unsigned A_PEND = 'h180, A_CMD = 'h1C0, A_ROUTE = 'h200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_irq;
  logic          nmi_irq, yield_irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_share_ctrl #(.NUM_SRC(NS), .NUM_PINS(NP), .ADDR_W(AW)) i_irq_share_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_irq(pin_irq), .nmi_irq(nmi_irq), .yield_irq(yield_irq));

  // Reference model state
  logic [NS-1:0] m_sense = '0, m_edge = '0, m_both = '0, m_en = '0, m_lat = '0, m_in = '0;
  logic [31:0]   m_route [NS];

  function automatic logic [NS-1:0] exp_pend();
    logic [NS-1:0] p;
    for (int n = 0; n < NS; n++)
      p[n] = m_edge[n] ? m_lat[n] : (m_sense[n] ? m_in[n] : ~m_in[n]);
    return p;
  endfunction

  function automatic logic [NP+1:0] exp_outs();  // {yield, nmi, pins}
    logic [NP+1:0] o = '0;
    logic [NS-1:0] live = exp_pend() & m_en;
    for (int n = 0; n < NS; n++) begin
      if (live[n]) begin
        if (m_route[n][31] && (m_route[n][5:0] < NP)) o[m_route[n][5:0]] = 1'b1;
        if (m_route[n][30]) o[NP] = 1'b1;
        if (m_route[n][29]) o[NP+1] = 1'b1;
      end
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int unsigned a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int unsigned a, output logic [31:0] d);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wr_sense(input int w, input logic [31:0] v);
    bus_write(A_SENSE + 4*w, v); m_sense[w*32 +: 32] = v;
  endtask
  task automatic wr_edge(input int w, input logic [31:0] v);
    bus_write(A_EDGE + 4*w, v); m_edge[w*32 +: 32] = v;
  endtask
  task automatic wr_both(input int w, input logic [31:0] v);
    bus_write(A_BOTH + 4*w, v); m_both[w*32 +: 32] = v;
  endtask
  task automatic en_set(input int w, input logic [31:0] v);
    bus_write(A_ENSET + 4*w, v); m_en[w*32 +: 32] = m_en[w*32 +: 32] | v;
  endtask
  task automatic en_clr(input int w, input logic [31:0] v);
    bus_write(A_ENCLR + 4*w, v); m_en[w*32 +: 32] = m_en[w*32 +: 32] & ~v;
  endtask
  task automatic wr_route(input int n, input logic [31:0] v);
    bus_write(A_ROUTE + 4*n, v); m_route[n] = v & 32'hE000_003F;
  endtask
  task automatic edge_cmd(input logic [31:0] v);
    bus_write(A_CMD, v);
    if (v[30:0] < NS) m_lat[v[30:0]] = v[31];
  endtask

  // Drive new input levels at a falling edge and update the latch model
  task automatic set_in(input logic [NS-1:0] nv);
    for (int n = 0; n < NS; n++) begin
      logic r = nv[n] & ~m_in[n];
      logic f = ~nv[n] & m_in[n];
      if (m_edge[n] && (m_both[n] ? (r | f) : (m_sense[n] ? r : f))) m_lat[n] = 1'b1;
    end
    m_in = nv;
    irq_in = nv;
  endtask

  task automatic check_outs(input string req);
    logic [NP+1:0] e = exp_outs();
    check({req, " pins"},  32'(pin_irq),   32'(e[NP-1:0]));
    check({req, " nmi"},   32'(nmi_irq),   32'(e[NP]));
    check({req, " yield"}, 32'(yield_irq), 32'(e[NP+1]));
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    logic [NS-1:0] p = exp_pend();
    for (int w = 0; w < NS/32; w++) begin
      bus_read(A_PEND + 4*w, d);   check({req, " pending word"}, d, p[w*32 +: 32]);
      bus_read(A_ENSTAT + 4*w, d); check({req, " enable status word"}, d, m_en[w*32 +: 32]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7351));
    for (int n = 0; n < NS; n++) m_route[n] = '0;
    tick(4);
    rst = 1'b0;
    tick(2);

    // R1: reset state
    check("R1 read data at reset", bus_rdata, 32'd0);
    check_outs("R1 outputs at reset");
    bus_read(A_SENSE, d);      check("R1 sense word0", d, 32'd0);
    bus_read(A_EDGE + 4, d);   check("R1 edge-mode word1", d, 32'd0);
    bus_read(A_ROUTE + 4*9, d); check("R1 route 9", d, 32'd0);
    check_state("R1 reset");

    // R10: latency, write-only, misaligned and unmapped reads
    wr_sense(0, 32'h1234_5678);
    bus_read(A_SENSE, d);       check("R10 one-cycle read latency", d, 32'h1234_5678);
    tick(2);                    check("R10 data held after read", bus_rdata, 32'h1234_5678);
    wr_sense(0, 32'h0);
    bus_read(A_ENSET, d);       check("R10 write-only set word reads 0", d, 32'd0);
    bus_read(A_ENCLR + 4, d);   check("R10 write-only clear word reads 0", d, 32'd0);
    bus_read(A_CMD, d);         check("R10 command word reads 0", d, 32'd0);
    bus_read(A_ENSTAT + 1, d);  check("R10 misaligned reads 0", d, 32'd0);
    bus_read('hFFC, d);         check("R10 unmapped reads 0", d, 32'd0);

    // R9: bit packing of the second bank word
    wr_edge(1, 32'h8000_0001);
    bus_read(A_EDGE + 4, d);    check("R9 edge-mode word1 readback", d, 32'h8000_0001);
    bus_read(A_EDGE, d);        check("R9 edge-mode word0 untouched", d, 32'd0);
    tick(2);
    bus_read(A_PEND + 4, d);    check("R9 pending sources 32 and 63", d, 32'h7FFF_FFFE);
    wr_edge(1, 32'h0);
    wr_route(4, 32'hFFFF_FFFF);
    bus_read(A_ROUTE + 16, d);  check("R9 route fields readback", d, 32'hE000_003F);
    wr_route(4, 32'h0);

    // R5: enable set/clear and zero bits
    en_set(0, 32'h9);
    bus_read(A_ENSTAT, d);      check("R5 enable after set", d, 32'h9);
    en_set(0, 32'h0);
    bus_read(A_ENSTAT, d);      check("R5 zero set bits no effect", d, 32'h9);
    en_clr(0, 32'h1);
    bus_read(A_ENSTAT, d);      check("R5 enable after clear", d, 32'h8);
    en_clr(0, 32'h0);
    bus_read(A_ENSTAT, d);      check("R5 zero clear bits no effect", d, 32'h8);

    // R2 / R11: level source 3, active high, to pin 2
    wr_route(3, 32'h8000_0002);
    wr_sense(0, 32'h8);
    tick(3);
    check("R2 level idle low", 32'(pin_irq), 32'h0);
    set_in(m_in | (NS'(1) << 3));
    tick(2);                    check("R11 pin not yet up after 2 edges", 32'(pin_irq), 32'h0);
    tick(1);                    check("R11 pin up after 3 edges", 32'(pin_irq), 32'h4);
    set_in(m_in & ~(NS'(1) << 3));
    tick(2);                    check("R11 pin still up after 2 edges", 32'(pin_irq), 32'h4);
    tick(1);                    check("R2 level follows input low", 32'(pin_irq), 32'h0);

    // R3: edge source 5, rising, to pin 0
    wr_sense(0, m_sense[31:0] | 32'h20);
    wr_edge(0, 32'h20);
    en_set(0, 32'h20);
    wr_route(5, 32'h8000_0000);
    set_in(m_in | (NS'(1) << 5)); tick(5);
    check("R3 rising edge latched", 32'(pin_irq[0]), 32'h1);
    set_in(m_in & ~(NS'(1) << 5)); tick(5);
    check("R3 latch holds after input drops", 32'(pin_irq[0]), 32'h1);
    check_state("R3 latched");
    edge_cmd(32'd5); tick(2);
    check("R6 clear command drops latch", 32'(pin_irq[0]), 32'h0);
    wr_sense(0, m_sense[31:0] & ~32'h20);
    set_in(m_in | (NS'(1) << 5)); tick(5);
    check("R3 falling-sense ignores rise", 32'(pin_irq[0]), 32'h0);
    set_in(m_in & ~(NS'(1) << 5)); tick(5);
    check("R3 falling-sense catches fall", 32'(pin_irq[0]), 32'h1);
    edge_cmd(32'd5); tick(2);

    // R4: both edges
    wr_both(0, 32'h20);
    set_in(m_in | (NS'(1) << 5)); tick(5);
    check("R4 both-edge catches rise", 32'(pin_irq[0]), 32'h1);
    edge_cmd(32'd5); tick(2);
    set_in(m_in & ~(NS'(1) << 5)); tick(5);
    check("R4 both-edge catches fall", 32'(pin_irq[0]), 32'h1);
    check_outs("R4 model");

    // R6: command set, out-of-range number
    wr_edge(0, m_edge[31:0] | 32'h80);
    edge_cmd(32'h8000_0007); tick(2);
    bus_read(A_PEND, d);        check("R6 set command latches source 7", d[7], 1'b1);
    edge_cmd(32'h8000_0040); tick(2);
    check_state("R6 out-of-range set ignored");
    edge_cmd(32'h0000_0007); tick(2);
    bus_read(A_PEND, d);        check("R6 clear command source 7", d[7], 1'b0);

    // R7 / R8: steering of latched source 5
    wr_route(5, 32'h4000_0000); tick(2);
    check("R8 nmi routed", 32'(nmi_irq), 32'h1);
    check("R8 nmi only, no pin", 32'(pin_irq), 32'h0);
    wr_route(5, 32'h2000_0000); tick(2);
    check("R8 yield routed", 32'(yield_irq), 32'h1);
    check("R8 nmi dropped", 32'(nmi_irq), 32'h0);
    wr_route(5, 32'h8000_003C); tick(2);
    check("R7 selector beyond pin count drives none", 32'(pin_irq), 32'h0);
    wr_route(5, 32'h8000_0007); tick(2);
    check("R7 top pin", 32'(pin_irq), 32'h80);
    en_clr(0, 32'h20); tick(2);
    check("R5 disabled source quiet", 32'(pin_irq), 32'h0);

    // Random phase
    for (int it = 0; it < 120; it++) begin
      int unsigned op = $urandom % 8;
      int unsigned w = $urandom % (NS/32);
      logic [31:0] v = $urandom;
      case (op)
        0: wr_sense(w, v);
        1: wr_edge(w, v);
        2: wr_both(w, v);
        3: en_set(w, v);
        4: en_clr(w, v & $urandom);
        5: wr_route($urandom % NS, (v & 32'hFFFF_FFC0) | 32'($urandom % 10));
        6: set_in(m_in ^ {$urandom, $urandom});
        default: edge_cmd({v[31], 31'($urandom % (NS + 2))});
      endcase
      tick(5);
      check_outs("R7 R8 random outputs");
      if (it % 4 == 0) check_state("R2 R3 R4 R5 R6 random state");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule